// File: doc/BRIEF.md
# Full-Epoch Parallel Matched-Filter Correlator with Sync Confirmation

This block searches for a known spreading code in two 1-bit baseband streams, one in-phase (I) and one quadrature (Q). Every accepted sample pair enters a tapped delay line that is exactly one code period long, with one tap per chip. Each window is compared in parallel against a loadable reference code, so every code phase is tested as the samples move through. There is no stepping through phases one at a time.

Each channel gives a signed agreement count. The absolute values of the two counts are added to form a magnitude metric, and the metric is compared with a threshold. A single crossing is not enough to declare sync, because noise and false-alarm targets rule that out. The block waits for a run of crossings, each lying exactly one code period after the one before. It then emits a one-cycle sync pulse and sets a sticky locked flag. Code tracking and data demodulation are handled downstream once lock is reported. A restart input re-arms the search.

Top module: `mf_epoch_correlator`

## Requirements
- R1: A sample pair enters the window only on a clock edge where `in_valid` is high. The window keeps the last LEN accepted pairs. With neither `in_valid` nor `ref_load` high, `metric` does not change.
- R2: For each channel, the sum adds +1 for each tap that agrees with the reference and -1 for each tap that disagrees. Reference bit k is compared with the sample accepted k samples before the newest, so bit 0 goes with the newest sample and bit LEN-1 with the oldest.
- R3: `metric` equals |sum_I| + |sum_Q|. It is valid in the cycle after the edge that accepted the sample. Its value is always even and never above 2*LEN.
- R4: `peak` is high only in the cycle after an accepting edge. It also requires that at least LEN samples have been accepted since reset, and that `metric` >= `thresh`.
- R5: A peak counts toward confirmation only if it comes exactly LEN accepted samples after the previous counted peak. When CONFIRM such peaks in a row have been seen, sync is declared.
- R6: If the window LEN samples after a counted peak is not a peak, the run count goes to zero. A peak that arrives earlier than that distance starts a new run, counting as its first peak.
- R7: `sync_pulse` is high for one cycle only, in the cycle after the confirming peak's cycle. `locked` rises together with it and then stays high. While `locked` is high, no further pulses are produced.
- R8: `restart` clears `locked` and the run count. `ref_load` loads `ref_code` and clears the run count. Both take priority over peak counting in the same cycle.
- R9: After reset the window and the reference are all zeros, the fill count is zero, and `peak`, `sync_pulse` and `locked` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample pair strobe |
| in_i | input | 1 | In-phase sample |
| in_q | input | 1 | Quadrature sample |
| ref_load | input | 1 | Load strobe for the reference code |
| ref_code | input | LEN | Reference code; bit 0 goes with the newest sample |
| thresh | input | MW | Peak threshold on the metric |
| restart | input | 1 | Clears lock and restarts the search |
| metric | output | MW | |sum_I| + |sum_Q| of the current window |
| peak | output | 1 | Current fresh window crosses the threshold |
| sync_pulse | output | 1 | One-cycle sync declaration |
| locked | output | 1 | Sticky lock flag |

## Verification
The hardest case to reach from the ports is a run of peaks that is interrupted. The interruption can be a missed epoch or a single stray sample that moves every later peak one position away from the expected spacing. The bench produces both by streaming whole code periods and splicing in either a period of constant chips or one extra sample. It also drives ordinary and inverted I periods, so the absolute-value step is exercised. A bench model, written from the requirements, predicts the metric, the peak, the pulse and the lock for every sample. The metric is also swept over every I byte pattern against a fixed reference.

// File: rtl/mf_epoch_correlator.sv
module mf_epoch_correlator #(
  parameter int LEN     = 16,
  parameter int CONFIRM = 3,
  localparam int MW = $clog2(2 * LEN + 1),
  localparam int CW = $clog2(LEN + 1),
  localparam int GW = (LEN > 2) ? $clog2(LEN) : 1,
  localparam int HW = $clog2(CONFIRM + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           in_i,
  input  logic           in_q,
  input  logic           ref_load,
  input  logic [LEN-1:0] ref_code,
  input  logic [MW-1:0]  thresh,
  input  logic           restart,
  output logic [MW-1:0]  metric,
  output logic           peak,
  output logic           sync_pulse,
  output logic           locked
);

  logic [LEN-1:0] line_i, line_q, ref_r;
  logic [CW-1:0]  fill;
  logic           fresh;
  logic [GW-1:0]  gap;
  logic [HW-1:0]  hits;
  logic [CW-1:0]  agree_i, agree_q;
  logic [MW-1:0]  mag_i, mag_q;

  localparam logic [MW-1:0] LEN_M = MW'(LEN);

  // R1: delay line, newest sample at bit 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_i <= '0;
      line_q <= '0;
      fill   <= '0;
      fresh  <= 1'b0;
    end else begin
      fresh <= in_valid;
      if (in_valid) begin
        line_i <= {line_i[LEN-2:0], in_i};
        line_q <= {line_q[LEN-2:0], in_q};
        if (fill != CW'(LEN)) fill <= fill + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ref_r <= '0;
    else if (ref_load) ref_r <= ref_code;
  end

  // R2: tap agreement counts
  always_comb begin
    agree_i = '0;
    agree_q = '0;
    for (int k = 0; k < LEN; k++) begin
      agree_i = agree_i + CW'(line_i[k] ~^ ref_r[k]);
      agree_q = agree_q + CW'(line_q[k] ~^ ref_r[k]);
    end
  end

  // R3: |2a - LEN| per channel, then summed
  function automatic logic [MW-1:0] mag(input logic [CW-1:0] a);
    logic [MW-1:0] twice;
    twice = MW'(a) << 1;
    return (twice >= LEN_M) ? twice - LEN_M : LEN_M - twice;
  endfunction

  assign mag_i  = mag(agree_i);
  assign mag_q  = mag(agree_q);
  assign metric = mag_i + mag_q;

  // R4
  assign peak = fresh && (fill == CW'(LEN)) && (metric >= thresh);

  // R5 R6 R7 R8: confirmation of evenly spaced peaks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hits       <= '0;
      gap        <= '0;
      locked     <= 1'b0;
      sync_pulse <= 1'b0;
    end else begin
      sync_pulse <= 1'b0;
      if (restart || ref_load) begin
        hits <= '0;
        gap  <= '0;
        if (restart) locked <= 1'b0;
      end else if (fresh && !locked) begin
        if (hits == '0) begin
          if (peak) begin
            hits <= HW'(1);
            gap  <= '0;
          end
        end else if (gap == GW'(LEN - 1)) begin
          if (!peak) begin
            hits <= '0;
          end else if (hits == HW'(CONFIRM - 1)) begin
            sync_pulse <= 1'b1;
            locked     <= 1'b1;
            hits       <= '0;
          end else begin
            hits <= hits + 1'b1;
            gap  <= '0;
          end
        end else if (peak) begin
          hits <= HW'(1);
          gap  <= '0;
        end else begin
          gap <= gap + 1'b1;
        end
      end
    end
  end

  // R1
  metric_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !ref_load) |=> $stable(metric));

  // R3
  metric_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (metric[0] == 1'b0) && (metric <= MW'(2 * LEN)));

  // R4
  peak_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    peak |-> (fill == CW'(LEN)));

  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> !sync_pulse);

  // R7
  pulse_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |-> locked && !$past(locked));

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !restart) |=> locked);

  // R8
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !locked);

endmodule

// File: tb/mf_epoch_correlator_tb_top.sv
module mf_epoch_correlator_tb_top;
  localparam int LEN     = 8;
  localparam int CONFIRM = 3;
  localparam int MW      = $clog2(2 * LEN + 1);
  localparam int CLK_PERIOD = 10;
  localparam logic [LEN-1:0] CODE = 8'b1011_0010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_i = 1'b0, in_q = 1'b0;
  logic ref_load = 1'b0, restart = 1'b0;
  logic [LEN-1:0] ref_code = '0;
  logic [MW-1:0]  thresh = '0;
  logic [MW-1:0]  metric;
  logic peak, sync_pulse, locked;

  int errors = 0, checks = 0, pulses = 0;
  bit done = 0;

  logic [LEN-1:0] m_wi = '0, m_wq = '0, m_ref = '0;
  int m_fill = 0, m_hits = 0, m_dist = 0;
  bit m_locked = 0, m_pulse = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mf_epoch_correlator #(.LEN(LEN), .CONFIRM(CONFIRM)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .ref_load(ref_load), .ref_code(ref_code), .thresh(thresh), .restart(restart),
    .metric(metric), .peak(peak), .sync_pulse(sync_pulse), .locked(locked));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_metric();
    int si = 0, sq = 0;
    for (int k = 0; k < LEN; k++) begin
      si += (m_wi[k] == m_ref[k]) ? 1 : -1;
      sq += (m_wq[k] == m_ref[k]) ? 1 : -1;
    end
    return (si < 0 ? -si : si) + (sq < 0 ? -sq : sq);
  endfunction

  task automatic send(input logic vi, input logic vq, input bit check_sync);
    int em;
    bit ep;
    @(negedge clk);
    in_valid = 1'b1; in_i = vi; in_q = vq;
    m_wi = {m_wi[LEN-2:0], vi};
    m_wq = {m_wq[LEN-2:0], vq};
    if (m_fill < LEN) m_fill++;
    @(negedge clk);
    in_valid = 1'b0;
    em = exp_metric();
    ep = (m_fill == LEN) && (em >= int'(thresh));
    chk("R2 R3 metric", int'(metric), em);
    chk("R4 peak", int'(peak), int'(ep));
    m_pulse = 0;
    if (!m_locked) begin
      if (m_hits == 0) begin
        if (ep) begin m_hits = 1; m_dist = 0; end
      end else begin
        m_dist++;
        if (m_dist == LEN) begin
          if (!ep) m_hits = 0;
          else if (m_hits == CONFIRM - 1) begin m_pulse = 1; m_locked = 1; m_hits = 0; end
          else begin m_hits++; m_dist = 0; end
        end else if (ep) begin
          m_hits = 1; m_dist = 0;
        end
      end
    end
    @(negedge clk);
    if (sync_pulse) pulses++;
    if (check_sync) begin
      chk("R5 R6 R7 sync_pulse", int'(sync_pulse), int'(m_pulse));
      chk("R7 locked", int'(locked), int'(m_locked));
    end
  endtask

  task automatic epoch(input bit inv_i, input bit inv_q);
    for (int k = LEN - 1; k >= 0; k--) send(CODE[k] ^ inv_i, CODE[k] ^ inv_q, 1);
  endtask

  task automatic do_restart();
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    m_locked = 0; m_hits = 0; m_dist = 0;
    chk("R8 restart clears locked", int'(locked), 0);
  endtask

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 peak after reset", int'(peak), 0);
    chk("R9 sync after reset", int'(sync_pulse), 0);
    chk("R9 locked after reset", int'(locked), 0);
    chk("R9 metric of zero window and zero code", int'(metric), 2 * LEN);

    // R4 fill rule and R6 early peaks: all-zero stream against zero code
    thresh = MW'(2 * LEN);
    for (int n = 0; n < 3 * LEN; n++) send(1'b0, 1'b0, 1);

    // R8 ref_load: load code, R1 hold with no strobe
    @(negedge clk); ref_code = CODE; ref_load = 1'b1;
    @(negedge clk); ref_load = 1'b0; m_ref = CODE; m_hits = 0; m_dist = 0;
    chk("R8 metric after ref_load", int'(metric), exp_metric());
    repeat (4) @(negedge clk);
    chk("R1 metric held without strobe", int'(metric), exp_metric());

    // R2 R3 sweep of every I byte, Q its bit reverse, no peaks possible
    thresh = MW'(2 * LEN + 1);
    for (int v = 0; v < 256; v++)
      for (int b = 0; b < LEN; b++) send(v[b], v[LEN-1-b], 1);
    chk("R4 no sync with unreachable threshold", int'(locked), 0);

    // R5 R7 three aligned epochs, inverted I also counts
    thresh = MW'(2 * LEN);
    do_restart();
    pulses = 0;
    epoch(0, 0); epoch(1, 0); epoch(0, 1);
    chk("R5 one pulse after three epochs", pulses, 1);
    chk("R7 locked after confirm", int'(locked), 1);
    epoch(0, 0); epoch(0, 0); epoch(0, 0);
    chk("R7 no pulse while locked", pulses, 1);
    do_restart();

    // R6 missed epoch breaks the run
    pulses = 0;
    epoch(0, 0); epoch(0, 0);
    for (int k = 0; k < LEN; k++) send(1'b0, 1'b0, 1);
    epoch(0, 0); epoch(0, 0);
    chk("R6 missed epoch: no pulse yet", pulses, 0);
    epoch(0, 0);
    chk("R6 pulse after fresh run of three", pulses, 1);
    do_restart();

    // R6 misplaced peak: one extra sample shifts the spacing
    pulses = 0;
    epoch(0, 0); epoch(0, 0);
    send(1'b1, 1'b0, 1);
    epoch(0, 0); epoch(0, 0);
    chk("R6 misplaced peak: no pulse yet", pulses, 0);
    p0 = pulses;
    epoch(1, 1);
    chk("R6 pulse after realigned run", pulses - p0, 1);

    // R8 ref_load mid-run clears count
    do_restart();
    pulses = 0;
    epoch(0, 0); epoch(0, 0);
    @(negedge clk); ref_load = 1'b1;
    @(negedge clk); ref_load = 1'b0; m_hits = 0; m_dist = 0;
    epoch(0, 0);
    chk("R8 ref_load restarts count", pulses, 0);
    epoch(0, 0); epoch(0, 0);
    chk("R8 pulse after reload run", pulses, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule